// File: doc/BRIEF.md
# Eight-Channel DAC Command Decoder

This block sits behind a serial receiver and turns each 16-bit command word, offered together with a one-cycle valid strobe, into changes to a bank of eight 8-bit channel registers and eight 8-bit output codes. The output codes feed eight converters. Each channel keeps two values. The register is a staging value. The output code is what the converter actually shows.

A mode bit decides whether a plain channel write reaches only the register or also the output. Three group commands act on several channels in one cycle: a masked copy from register to output, a write to the first channel that also refreshes all the others, and a broadcast of one value to every channel. Each channel also holds a power-down state with one of three output terminations. A shared bias-enable output drops only when every channel is powered down.

Top module: `dac8_cmd_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, all channel registers and output codes become 0, every termination becomes 2'b00 (active), the mode becomes register-only (wt_mode_o=0) and bias_en_o is 1.
- R2: A word with bit 15 = 0 is a channel write. Bits 14:12 select the channel (0 = first channel, lowest byte of the flat buses; 7 = last channel, highest byte). Bits 11:4 carry the code, and bits 3:0 have no effect.
- R3: In register-only mode a channel write changes that channel's register in the next cycle and leaves every output code unchanged.
- R4: In write-through mode a channel write loads both the register and the output code of the selected channel.
- R5: Bits 15:12 = 4'h8 select register-only mode and 4'h9 select write-through mode. The mode persists through all other commands.
- R6: Bits 15:12 = 4'hA copy the register to the output code, in the same cycle, for every channel whose bit in bits 7:0 is 1 (bit 0 = first channel).
- R7: Bits 15:12 = 4'hB load the first channel's register and output from bits 11:4 and, in the same cycle, copy every other channel's register to its output. The mode is unchanged.
- R8: Bits 15:12 = 4'hC load bits 11:4 into all eight registers and all eight output codes.
- R9: Bits 15:12 = 4'hD, 4'hE and 4'hF power down every channel whose mask bit (bits 7:0) is 1. The termination code becomes 2'b01 (high impedance), 2'b10 (100 kOhm) or 2'b11 (2.5 kOhm) respectively, and pd_o of that channel becomes 1. Channels that are already down take the new code.
- R10: A power-down command never changes any register or output code.
- R11: bias_en_o is 0 exactly when all eight channels are powered down.
- R12: Any command that loads a channel's output code returns that channel's termination to 2'b00 and clears its pd_o in the same cycle. Mode commands do not wake a channel.
- R13: A word offered while cmd_valid is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word valid this cycle |
| cmd_word | input | 16 | Command word |
| reg_code_o | output | 64 | Channel registers, byte i = channel i |
| out_code_o | output | 64 | Output codes, byte i = channel i |
| term_o | output | 16 | Termination codes, bits 2i+1:2i = channel i |
| pd_o | output | 8 | Per-channel powered-down flag |
| wt_mode_o | output | 1 | 1 = write-through mode |
| bias_en_o | output | 1 | Shared bias enable |

## Verification
Two functions can land on one channel in the same cycle: an output load and the release of that channel from power-down. The first-channel write also loads its own data while it copies the seven other registers to their outputs. The bench powers channels down, then issues a masked update, a broadcast and a write-through channel write. After each one it checks in one sample that the code, the termination and the bias all moved together. A separate vector sends the first-channel write after registers have been staged in register-only mode. That vector checks that every output changes on that single edge.

// File: rtl/dac8_pkg.sv
// Shared constants and types for the eight-channel DAC command decoder.
// Assumes a fixed 16-bit command word. The channel select field is wide
// enough for CH_NUM channels.
package dac8_pkg;
    localparam int CH_NUM = 8;
    localparam int CODE_W = 8;
    localparam int CMD_W  = 16;
    localparam int SEL_W  = $clog2(CH_NUM);
    localparam int TERM_W = 2;

    // Termination state of one channel output
    typedef enum logic [TERM_W-1:0] {
        TERM_ACTIVE = 2'b00,
        TERM_HIZ    = 2'b01,
        TERM_100K   = 2'b10,
        TERM_2K5    = 2'b11
    } term_e;

    // Group command opcodes in bits 15:12 (bit 15 set)
    typedef enum logic [3:0] {
        OP_REG_ONLY = 4'h8,
        OP_WR_THRU  = 4'h9,
        OP_UPD_SEL  = 4'hA,
        OP_CHA_WR   = 4'hB,
        OP_BCAST    = 4'hC,
        OP_PD_HIZ   = 4'hD,
        OP_PD_100K  = 4'hE,
        OP_PD_2K5   = 4'hF
    } op_e;

    // Per-cycle control bundle from the decoder to the channels
    typedef struct packed {
        logic [CH_NUM-1:0] reg_we;
        logic [CH_NUM-1:0] out_from_data;
        logic [CH_NUM-1:0] out_from_reg;
        logic [CH_NUM-1:0] pd_set;
        term_e             pd_term;
        logic [CODE_W-1:0] wdata;
        logic              mode_we;
        logic              mode_val;
    } chan_ctl_t;
endpackage

// File: rtl/dac8_cmd_decode.sv
// Command decoder: turns one valid command word into per-channel write,
// update and power-down strobes for this cycle. Purely combinational.
// Assumes the current mode bit is supplied by the caller.
module dac8_cmd_decode
    import dac8_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             wt_mode,
    output chan_ctl_t        ctl
);
    logic [SEL_W-1:0]  sel;
    logic [CH_NUM-1:0] mask;
    logic [3:0]        op;

    assign sel  = cmd_word[12 +: SEL_W];
    assign mask = cmd_word[CH_NUM-1:0];
    assign op   = cmd_word[15:12];

    // Build the strobe bundle for the offered word
    always_comb begin
        ctl         = '0;
        ctl.pd_term = TERM_ACTIVE;
        ctl.wdata   = cmd_word[4 +: CODE_W];
        if (cmd_valid) begin
            if (!cmd_word[15]) begin
                ctl.reg_we[sel]        = 1'b1;
                ctl.out_from_data[sel] = wt_mode;
            end else begin
                case (op)
                    OP_REG_ONLY: begin
                        ctl.mode_we  = 1'b1;
                        ctl.mode_val = 1'b0;
                    end
                    OP_WR_THRU: begin
                        ctl.mode_we  = 1'b1;
                        ctl.mode_val = 1'b1;
                    end
                    OP_UPD_SEL: ctl.out_from_reg = mask;
                    OP_CHA_WR: begin
                        ctl.reg_we[0]        = 1'b1;
                        ctl.out_from_data[0] = 1'b1;
                        ctl.out_from_reg     = {{(CH_NUM-1){1'b1}}, 1'b0};
                    end
                    OP_BCAST: begin
                        ctl.reg_we        = '1;
                        ctl.out_from_data = '1;
                    end
                    default: begin
                        ctl.pd_set  = mask;
                        ctl.pd_term = term_e'(cmd_word[13:12]);
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/dac8_channel.sv
// One channel: staging register, output code and termination state.
// Assumes an output load and a power-down never arrive together.
// An output load wins and wakes the channel.
module dac8_channel
    import dac8_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_we,
    input  logic         out_from_data,
    input  logic         out_from_reg,
    input  logic         pd_set,
    input  term_e        pd_term,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] reg_q,
    output logic [W-1:0] out_q,
    output term_e        term_q,
    output logic         pd_q
);
    // Staging register
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_q <= '0;
        else if (reg_we) reg_q <= wdata;
    end

    // Output code, loaded from the data field or from the register
    always_ff @(posedge clk) begin
        if (!rst_n)             out_q <= '0;
        else if (out_from_data) out_q <= wdata;
        else if (out_from_reg)  out_q <= reg_q;
    end

    // Termination state: an output load wakes, a power-down sets
    always_ff @(posedge clk) begin
        if (!rst_n)                            term_q <= TERM_ACTIVE;
        else if (out_from_data | out_from_reg) term_q <= TERM_ACTIVE;
        else if (pd_set)                       term_q <= pd_term;
    end

    // Powered-down flag
    always_comb pd_q = (term_q != TERM_ACTIVE);
endmodule

// File: rtl/dac8_bias.sv
// Shared bias control: enabled while at least one channel is awake.
// Assumes one powered-down flag per channel.
module dac8_bias #(
    parameter int N = 8
) (
    input  logic [N-1:0] pd,
    output logic         bias_en
);
    // Drop bias only when every channel is down
    always_comb bias_en = ~(&pd);
endmodule

// File: rtl/dac8_cmd_decoder.sv
// Top: eight-channel DAC command decoder. Holds the mode bit, decodes
// each valid word and drives the channel bank and the shared bias.
// Assumes commands arrive as single-cycle strobes on cmd_valid.
module dac8_cmd_decoder
    import dac8_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [CMD_W-1:0]         cmd_word,
    output logic [CH_NUM*CODE_W-1:0] reg_code_o,
    output logic [CH_NUM*CODE_W-1:0] out_code_o,
    output logic [CH_NUM*TERM_W-1:0] term_o,
    output logic [CH_NUM-1:0]        pd_o,
    output logic                     wt_mode_o,
    output logic                     bias_en_o
);
    chan_ctl_t ctl;

    dac8_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .wt_mode   (wt_mode_o),
        .ctl       (ctl)
    );

    // Mode bit: register-only after reset
    always_ff @(posedge clk) begin
        if (!rst_n)           wt_mode_o <= 1'b0;
        else if (ctl.mode_we) wt_mode_o <= ctl.mode_val;
    end

    for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
        term_e term_w;
        dac8_channel #(.W(CODE_W)) u_ch (
            .clk           (clk),
            .rst_n         (rst_n),
            .reg_we        (ctl.reg_we[i]),
            .out_from_data (ctl.out_from_data[i]),
            .out_from_reg  (ctl.out_from_reg[i]),
            .pd_set        (ctl.pd_set[i]),
            .pd_term       (ctl.pd_term),
            .wdata         (ctl.wdata),
            .reg_q         (reg_code_o[i*CODE_W +: CODE_W]),
            .out_q         (out_code_o[i*CODE_W +: CODE_W]),
            .term_q        (term_w),
            .pd_q          (pd_o[i])
        );
        assign term_o[i*TERM_W +: TERM_W] = term_w;
    end

    dac8_bias #(.N(CH_NUM)) u_bias (
        .pd      (pd_o),
        .bias_en (bias_en_o)
    );
endmodule

// File: rtl/dac8_cmd_decoder_chk.sv
// Checker for the command decoder, bound to the top module by name.
module dac8_cmd_decoder_chk
    import dac8_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_valid,
    input logic [CMD_W-1:0]         cmd_word,
    input logic [CH_NUM*CODE_W-1:0] reg_code_o,
    input logic [CH_NUM*CODE_W-1:0] out_code_o,
    input logic [CH_NUM*TERM_W-1:0] term_o,
    input logic [CH_NUM-1:0]        pd_o,
    input logic                     wt_mode_o,
    input logic                     bias_en_o
);
    // R1: reset clears all state
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (reg_code_o == '0 && out_code_o == '0 && term_o == '0 && !wt_mode_o));

    // R3: register-only channel write keeps outputs
    a_r3_reg_only_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_word[15] && !wt_mode_o) |=> $stable(out_code_o));

    // R5: mode selection
    a_r5_mode_wt: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[15:12] == 4'h9) |=> wt_mode_o);
    a_r5_mode_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[15:12] == 4'h8) |=> !wt_mode_o);

    // R7: first-channel write refreshes the others
    a_r7_cha_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[15:12] == 4'hB) |=>
        (out_code_o[CH_NUM*CODE_W-1:CODE_W] == $past(reg_code_o[CH_NUM*CODE_W-1:CODE_W])
         && out_code_o[CODE_W-1:0] == $past(cmd_word[4 +: CODE_W])));

    // R10: power-down leaves codes alone
    a_r10_pd_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[15:12] >= 4'hD) |=> ($stable(reg_code_o) && $stable(out_code_o)));

    // R11: full-mask power-down drops bias
    a_r11_bias_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[15:12] >= 4'hD && cmd_word[7:0] == 8'hFF) |=> !bias_en_o);

    // R12: a changed output code means the channel is awake
    for (genvar i = 0; i < CH_NUM; i++) begin : g_wake
        a_r12_update_wakes: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(out_code_o[i*CODE_W +: CODE_W]) |-> !pd_o[i]);
    end
endmodule

bind dac8_cmd_decoder dac8_cmd_decoder_chk chk_i (.*);

// File: tb/dac8_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module dac8_cmd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [63:0] reg_code_o, out_code_o;
    logic [15:0] term_o;
    logic [7:0]  pd_o;
    logic        wt_mode_o, bias_en_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dac8_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .reg_code_o(reg_code_o), .out_code_o(out_code_o), .term_o(term_o),
        .pd_o(pd_o), .wt_mode_o(wt_mode_o), .bias_en_o(bias_en_o)
    );

    typedef struct packed {
        logic [15:0] cmd;
        logic [63:0] regs;
        logic [63:0] outs;
        logic [15:0] term;
        logic        mode;
        logic        bias;
        int          req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{16'h22A5, 64'h0000_0000_002A_0000, 64'h0, 16'h0000, 1'b0, 1'b1, 2},                 // R2 R3
        '{16'h7F0F, 64'hF000_0000_002A_0000, 64'h0, 16'h0000, 1'b0, 1'b1, 2},                 // R2 low bits ignored
        '{16'hA004, 64'hF000_0000_002A_0000, 64'h0000_0000_002A_0000, 16'h0000, 1'b0, 1'b1, 6}, // R6
        '{16'h9000, 64'hF000_0000_002A_0000, 64'h0000_0000_002A_0000, 16'h0000, 1'b1, 1'b1, 5}, // R5
        '{16'h1330, 64'hF000_0000_002A_3300, 64'h0000_0000_002A_3300, 16'h0000, 1'b1, 1'b1, 4}, // R4
        '{16'hB7E0, 64'hF000_0000_002A_337E, 64'hF000_0000_002A_337E, 16'h0000, 1'b1, 1'b1, 7}, // R7
        '{16'h8000, 64'hF000_0000_002A_337E, 64'hF000_0000_002A_337E, 16'h0000, 1'b0, 1'b1, 5}, // R5
        '{16'h3440, 64'hF000_0000_442A_337E, 64'hF000_0000_002A_337E, 16'h0000, 1'b0, 1'b1, 3}, // R3
        '{16'hD00C, 64'hF000_0000_442A_337E, 64'hF000_0000_002A_337E, 16'h0050, 1'b0, 1'b1, 9}, // R9
        '{16'hE0F0, 64'hF000_0000_442A_337E, 64'hF000_0000_002A_337E, 16'hAA50, 1'b0, 1'b1, 10}, // R10
        '{16'hA008, 64'hF000_0000_442A_337E, 64'hF000_0000_442A_337E, 16'hAA10, 1'b0, 1'b1, 12}, // R12
        '{16'hC5A0, 64'h5A5A_5A5A_5A5A_5A5A, 64'h5A5A_5A5A_5A5A_5A5A, 16'h0000, 1'b0, 1'b1, 8},  // R8
        '{16'hF0FF, 64'h5A5A_5A5A_5A5A_5A5A, 64'h5A5A_5A5A_5A5A_5A5A, 16'hFFFF, 1'b0, 1'b0, 11}, // R11
        '{16'hD001, 64'h5A5A_5A5A_5A5A_5A5A, 64'h5A5A_5A5A_5A5A_5A5A, 16'hFFFD, 1'b0, 1'b0, 9},  // R9 recode
        '{16'h9000, 64'h5A5A_5A5A_5A5A_5A5A, 64'h5A5A_5A5A_5A5A_5A5A, 16'hFFFD, 1'b1, 1'b0, 5},  // R5 no wake
        '{16'h0110, 64'h5A5A_5A5A_5A5A_5A11, 64'h5A5A_5A5A_5A5A_5A11, 16'hFFFC, 1'b1, 1'b1, 12}  // R12 R11
    };

    function automatic logic [7:0] pd_of(input logic [15:0] t);
        for (int i = 0; i < 8; i++) pd_of[i] = (t[2*i +: 2] != 2'b00);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [63:0] r, input logic [63:0] o,
                             input logic [15:0] t, input logic m, input logic b);
        chk({tag, " reg"}, reg_code_o, r);
        chk({tag, " out"}, out_code_o, o);
        chk({tag, " term"}, {48'h0, term_o}, {48'h0, t});
        chk({tag, " pd"}, {56'h0, pd_o}, {56'h0, pd_of(t)});
        chk({tag, " mode/bias"}, {62'h0, wt_mode_o, bias_en_o}, {62'h0, m, b});
    endtask

    task automatic send(input logic [15:0] w, input logic v);
        @(negedge clk);
        cmd_word  = w;
        cmd_valid = v;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 reset", 64'h0, 64'h0, 16'h0, 1'b0, 1'b1);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            send(VECS[k].cmd, 1'b1);
            check_all($sformatf("R%0d vec%0d", VECS[k].req, k),
                      VECS[k].regs, VECS[k].outs, VECS[k].term, VECS[k].mode, VECS[k].bias);
        end
        // R13: broadcast word without the strobe is ignored
        send(16'hC000, 1'b0);
        check_all("R13 no strobe", 64'h5A5A_5A5A_5A5A_5A11, 64'h5A5A_5A5A_5A5A_5A11,
                  16'hFFFC, 1'b1, 1'b1);
        // R1: mid-run reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check_all("R1 mid reset", 64'h0, 64'h0, 16'h0, 1'b0, 1'b1);
        // R3: register-only again after reset, last channel write
        send(16'h7990, 1'b1);
        check_all("R3 after reset", 64'h9900_0000_0000_0000, 64'h0, 16'h0, 1'b0, 1'b1);
        // R7: first-channel write in register-only keeps mode, refreshes last channel
        send(16'hB010, 1'b1);
        check_all("R7 ro mode", 64'h9900_0000_0000_0001, 64'h9900_0000_0000_0001, 16'h0, 1'b0, 1'b1);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule